// File: doc/BRIEF.md
# Boot Region Write Guard

This block sits on the array write path, behind the command decoder. Every byte program or erase request that the decoder issues passes through it, and the block decides whether that request may reach the array. A 16 KB boot region at either the lowest or the highest end of a 1 MB address space can be frozen by a one-time lock. After the lock is set, requests that land in the region are held back. A separate override level lifts the protection for as long as it is held.

For byte programs, the block combines the word read back from the array with the incoming data. The result can only turn ones into zeros. For an erase, it supplies an all-ones word. The command decoder runs a chip erase as one erase request per address. Requests to protected addresses are then skipped silently, so the sweep does not abort. A program aimed at a protected byte is refused and reported with a one-cycle reject pulse.

Requests are also dropped when the supply-good flag is low, or when the bus strobes do not describe a write cycle. The outputs are registered: the verdict for a request sampled at one clock edge appears on the outputs directly after that edge.

Top module: `boot_write_filter`

## Requirements
- R1: A synchronous reset holds `wr_en` and `wr_reject` low and clears the lock. After reset is released, programs into the boot region are accepted until the lock is set again.
- R2: A `lock_set` pulse sets the lock at the clock edge where it is sampled. A request sampled at that same edge is still judged against the lock value it had before. Once set, the lock never clears, except by reset.
- R3: The boot region covers `BOOT_BYTES` bytes. With `BOOT_AT_TOP`=0 it spans 00000h to 03FFFh; with `BOOT_AT_TOP`=1 it spans FC000h to FFFFFh. Addresses outside the region are never protected.
- R4: A program request to a boot-region address, made while the lock is set and `prot_override` is low, produces no write and raises `wr_reject` for exactly one cycle.
- R5: While `prot_override` is 1, programs and erases in the boot region are accepted even when locked. Protection applies again to the first request sampled after `prot_override` returns to 0.
- R6: An erase request (`req_erase`=1) writes FFh to an unprotected address. An erase to a protected address produces neither a write nor a reject.
- R7: An accepted program (`req_erase`=0) writes `cell_data & req_data`.
- R8: No write and no reject are produced while `supply_ok` is 0.
- R9: A request is dropped, with no write and no reject, unless `bus_ce_n`=0, `bus_oe_n`=1 and `bus_we_n`=0.
- R10: An accepted request sampled at edge k drives `wr_en`=1 with `wr_addr`=`req_addr` after edge k, for one cycle. Back-to-back requests are each handled in their own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| req_valid | input | 1 | Write request from the command decoder |
| req_erase | input | 1 | 1 = erase this byte, 0 = program it |
| req_addr | input | ADDR_W | Byte address of the request |
| req_data | input | DATA_W | Data to program |
| cell_data | input | DATA_W | Current array contents at req_addr |
| bus_ce_n | input | 1 | Chip select level, active low |
| bus_oe_n | input | 1 | Output enable level, active low |
| bus_we_n | input | 1 | Write strobe level, active low |
| lock_set | input | 1 | Strobe that sets the sticky lock |
| prot_override | input | 1 | Level that lifts boot-region protection |
| supply_ok | input | 1 | Supply voltage is high enough to write |
| wr_en | output | 1 | Array write enable, one cycle per accepted request |
| wr_addr | output | ADDR_W | Address for the array write |
| wr_data | output | DATA_W | Masked word for the array write |
| wr_reject | output | 1 | One-cycle pulse for a refused program |

## Verification
The assertions assume that `cell_data` is the array's true contents at `req_addr` in the cycle of the request. They also assume that reset is applied before the first request, and that bus strobes and the override level are stable between clock edges. The stimulus holds every input constant from one falling edge to the next. It supplies the old cell value as an explicit operand, so no array model is needed. Two instances, one per region placement, share the same stimulus, so a single sequence exercises both region boundaries from either side.

// File: rtl/bootfilt_pkg.sv
package bootfilt_pkg;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } wop_e;

  typedef struct packed {
    logic pass;
    logic reject;
  } verdict_t;

  function automatic verdict_t judge(input logic qual, input logic guarded, input wop_e op);
    verdict_t v;
    v.pass   = qual && !guarded;
    v.reject = qual && guarded && (op == OP_PROGRAM);
    return v;
  endfunction

endpackage

// File: rtl/boot_lock_reg.sv
module boot_lock_reg (
  input  logic clk,
  input  logic rst,
  input  logic lock_set,
  output logic locked
);

  always_ff @(posedge clk) begin
    if (rst)           locked <= 1'b0;
    else if (lock_set) locked <= 1'b1;
  end

  // R2: the lock never drops without reset
  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (rst) locked |=> locked);
  a_r2_lock_takes: assert property (@(posedge clk) disable iff (rst) lock_set |=> locked);

endmodule

// File: rtl/boot_region_decode.sv
module boot_region_decode #(
  parameter int ADDR_W      = 20,
  parameter int BOOT_BYTES  = 16384,
  parameter bit BOOT_AT_TOP = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_boot
);

  localparam int BOOT_W = $clog2(BOOT_BYTES);

  generate
    if (BOOT_AT_TOP) begin : g_top
      assign in_boot = &addr[ADDR_W-1:BOOT_W];
    end else begin : g_bottom
      assign in_boot = ~|addr[ADDR_W-1:BOOT_W];
    end
  endgenerate

endmodule

// File: rtl/write_qualify.sv
module write_qualify (
  input  logic req_valid,
  input  logic bus_ce_n,
  input  logic bus_oe_n,
  input  logic bus_we_n,
  input  logic supply_ok,
  output logic qual
);

  logic bus_write;

  always_comb begin
    bus_write = !bus_ce_n && bus_oe_n && !bus_we_n;
    qual      = req_valid && bus_write && supply_ok;
  end

endmodule

// File: rtl/bit_clear_merge.sv
module bit_clear_merge
  import bootfilt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  wop_e              op,
  input  logic [DATA_W-1:0] cell_data,
  input  logic [DATA_W-1:0] new_data,
  output logic [DATA_W-1:0] merged
);

  always_comb begin
    if (op == OP_ERASE) merged = '1;
    else                merged = cell_data & new_data;
  end

endmodule

// File: rtl/boot_write_filter.sv
module boot_write_filter
  import bootfilt_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 8,
  parameter int BOOT_BYTES  = 16384,
  parameter bit BOOT_AT_TOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [DATA_W-1:0] cell_data,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic              lock_set,
  input  logic              prot_override,
  input  logic              supply_ok,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_reject
);

  logic              locked;
  logic              in_boot;
  logic              qual;
  logic              guarded;
  logic [DATA_W-1:0] merged;
  wop_e              op;
  verdict_t          verdict;

  assign op = wop_e'(req_erase);

  boot_lock_reg u_lock (
    .clk      (clk),
    .rst      (rst),
    .lock_set (lock_set),
    .locked   (locked)
  );

  boot_region_decode #(
    .ADDR_W      (ADDR_W),
    .BOOT_BYTES  (BOOT_BYTES),
    .BOOT_AT_TOP (BOOT_AT_TOP)
  ) u_region (
    .addr    (req_addr),
    .in_boot (in_boot)
  );

  write_qualify u_qual (
    .req_valid (req_valid),
    .bus_ce_n  (bus_ce_n),
    .bus_oe_n  (bus_oe_n),
    .bus_we_n  (bus_we_n),
    .supply_ok (supply_ok),
    .qual      (qual)
  );

  bit_clear_merge #(
    .DATA_W (DATA_W)
  ) u_merge (
    .op        (op),
    .cell_data (cell_data),
    .new_data  (req_data),
    .merged    (merged)
  );

  always_comb begin
    guarded = locked && !prot_override && in_boot;
    verdict = judge(qual, guarded, op);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      wr_reject <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en     <= verdict.pass;
      wr_reject <= verdict.reject;
      if (qual) begin
        wr_addr <= req_addr;
        wr_data <= merged;
      end
    end
  end

  // R4: a refused program never writes
  a_r4_reject_excl: assert property (@(posedge clk) disable iff (rst) wr_reject |-> !wr_en);
  // R8: low supply blocks everything
  a_r8_supply_gate: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!wr_en && !wr_reject));
  // R9: only a proper bus write cycle counts
  a_r9_bus_gate: assert property (@(posedge clk) disable iff (rst)
    (bus_ce_n || !bus_oe_n || bus_we_n) |=> (!wr_en && !wr_reject));
  // R5: override never produces a refusal
  a_r5_override_pass: assert property (@(posedge clk) disable iff (rst)
    (qual && prot_override) |=> (wr_en && !wr_reject));
  // R6: an erase writes all ones or nothing, never a refusal
  a_r6_erase_fill: assert property (@(posedge clk) disable iff (rst)
    (qual && req_erase) |=> (!wr_reject && (!wr_en || wr_data == '1)));
  // R7: programs never raise a bit above the old cell
  a_r7_clear_only: assert property (@(posedge clk) disable iff (rst)
    (qual && !req_erase) |=> (!wr_en || ((wr_data & ~$past(cell_data)) == '0)));
  // R10: unprotected qualified requests are always written
  a_r10_open_write: assert property (@(posedge clk) disable iff (rst)
    (qual && !in_boot) |=> (wr_en && wr_addr == $past(req_addr)));

endmodule

// File: tb/test_boot_write_filter.sv
module test_boot_write_filter;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_erase = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0, cell_data = '0;
  logic bus_ce_n = 1'b0, bus_oe_n = 1'b1, bus_we_n = 1'b0;
  logic lock_set = 1'b0, prot_override = 1'b0, supply_ok = 1'b1;

  logic          lo_en, lo_rej, hi_en, hi_rej;
  logic [AW-1:0] lo_addr, hi_addr;
  logic [DW-1:0] lo_data, hi_data;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model state
  bit m_lock = 1'b0;
  bit e_en[2], e_rej[2];
  int e_addr[2], e_data[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_write_filter #(.BOOT_AT_TOP(1'b0)) i_boot_write_filter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data), .cell_data(cell_data),
    .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .lock_set(lock_set), .prot_override(prot_override), .supply_ok(supply_ok),
    .wr_en(lo_en), .wr_addr(lo_addr), .wr_data(lo_data), .wr_reject(lo_rej));

  boot_write_filter #(.BOOT_AT_TOP(1'b1)) i_boot_write_filter_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data), .cell_data(cell_data),
    .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .lock_set(lock_set), .prot_override(prot_override), .supply_ok(supply_ok),
    .wr_en(hi_en), .wr_addr(hi_addr), .wr_data(hi_data), .wr_reject(hi_rej));

  // behavioural model, one step per rising edge
  always @(posedge clk) begin
    bit go, prot;
    int a;
    a  = int'(req_addr);
    go = req_valid && !bus_ce_n && bus_oe_n && !bus_we_n && supply_ok;
    for (int v = 0; v < 2; v++) begin
      if (rst) begin
        e_en[v] = 0; e_rej[v] = 0;
      end else begin
        prot = (v == 0) ? (a < 16384) : (a >= 1048576 - 16384);
        prot = prot && m_lock && !prot_override;
        e_en[v]   = go && !prot;
        e_rej[v]  = go && prot && !req_erase;
        e_addr[v] = a;
        e_data[v] = req_erase ? 255 : int'(cell_data & req_data);
      end
    end
    if (rst) m_lock = 0;
    else if (lock_set) m_lock = 1;
  end

  task automatic cmp(input string who, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, who, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done && $time > CLK_PERIOD) begin
      cmp("lo.wr_en", int'(lo_en), int'(e_en[0]));
      cmp("lo.wr_reject", int'(lo_rej), int'(e_rej[0]));
      cmp("hi.wr_en", int'(hi_en), int'(e_en[1]));
      cmp("hi.wr_reject", int'(hi_rej), int'(e_rej[1]));
      if (e_en[0]) begin
        cmp("lo.wr_addr", int'(lo_addr), e_addr[0]);
        cmp("lo.wr_data", int'(lo_data), e_data[0]);
      end
      if (e_en[1]) begin
        cmp("hi.wr_addr", int'(hi_addr), e_addr[1]);
        cmp("hi.wr_data", int'(hi_data), e_data[1]);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    req_valid = 0; lock_set = 0;
  endtask

  task automatic req(input bit erase, input int a, input int d, input int c);
    @(negedge clk);
    req_valid = 1; req_erase = erase; lock_set = 0;
    req_addr = AW'(a); req_data = DW'(d); cell_data = DW'(c);
  endtask

  task automatic sweep(input bit erase);
    int pts[6] = '{32'h00000, 32'h03FFF, 32'h04000, 32'hFBFFF, 32'hFC000, 32'hFFFFF};
    for (int i = 0; i < 6; i++) req(erase, pts[i], 8'h5A ^ i, 8'hF3);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    idle();
    // R7: bit-clearing merge with distinct patterns
    cur_req = "R7";
    req(0, 32'h12345, 8'h3C, 8'hA5);
    req(0, 32'h80000, 8'hFF, 8'h0F);
    req(0, 32'h40001, 8'h00, 8'hFF);
    req(0, 32'h7FFFF, 8'hF0, 8'h3C);
    idle();
    // R3: unlocked region edges all accepted
    cur_req = "R3";
    sweep(0);
    // R2: lock with a same-edge protected request, which still passes
    cur_req = "R2";
    @(negedge clk);
    req_valid = 1; req_erase = 0; req_addr = 20'h00100; req_data = 8'h11; cell_data = 8'hFF;
    lock_set = 1;
    @(negedge clk);
    lock_set = 0; req_addr = 20'hFC100;
    idle();
    // R4: locked programs across region edges
    cur_req = "R4";
    sweep(0);
    // R5: override lifts protection, then releases it
    cur_req = "R5";
    @(negedge clk) prot_override = 1;
    sweep(0);
    sweep(1);
    @(negedge clk) prot_override = 0;
    sweep(0);
    // R6: erase sweep skips the locked region silently
    cur_req = "R6";
    sweep(1);
    // R8: supply low blocks writes
    cur_req = "R8";
    @(negedge clk) supply_ok = 0;
    req(0, 32'h20000, 8'h00, 8'hFF);
    req(1, 32'h20001, 8'h00, 8'hFF);
    idle();
    @(negedge clk) supply_ok = 1;
    // R9: bad bus strobes drop the request
    cur_req = "R9";
    @(negedge clk) bus_ce_n = 1;
    req(0, 32'h30000, 8'h00, 8'hFF);
    @(negedge clk) begin bus_ce_n = 0; bus_oe_n = 0; end
    req(0, 32'h30001, 8'h00, 8'hFF);
    @(negedge clk) begin bus_oe_n = 1; bus_we_n = 1; end
    req(1, 32'h30002, 8'h00, 8'hFF);
    @(negedge clk) bus_we_n = 0;
    idle();
    // R10: back-to-back requests every cycle
    cur_req = "R10";
    for (int i = 0; i < 16; i++) req(i[0], 32'h10000 + i * 4099, i * 37, 255 - i * 11);
    idle();
    // R2: lock still held after a long quiet stretch
    cur_req = "R2";
    repeat (20) idle();
    sweep(0);
    // R1: reset clears the lock
    cur_req = "R1";
    @(negedge clk) rst = 1;
    req(0, 32'h00000, 8'h00, 8'hFF);
    idle();
    @(negedge clk) rst = 0;
    sweep(0);
    repeat (3) idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule